// File: doc/BRIEF.md
# Multicycle Register-Memory Multiply Sequencer

This block is a small multicycle processor core. It fetches 32-bit instruction words from a byte-addressed memory over a simple read bus, decodes them and executes one operation: a register-memory multiply. Each instruction word carries a 4-bit opcode in bits 31:28, a 4-bit register index in bits 27:24 and a 24-bit direct memory address in bits 23:0. With opcode 5, register r is replaced by the low 32 bits of the signed product of itself and the memory word at that address. Any other opcode retires with no further effect.

Each memory access holds chip select and read high, with a size code of 4 bytes, for a fixed latency of `MEM_LAT` cycles (100 by default). The read word is captured on the last of those cycles. A multiply therefore takes two long accesses, one for the fetch and one for the operand. A no-op takes only the fetch. A side port lets the environment preload and inspect the sixteen 32-bit registers. A one-cycle retire strobe and the program counter show progress.

Top module: `mpy_seq`

## Requirements
- R1: While rst_ni is low, pc_o equals the parameter RESET_VEC (default 0x000100), the bus is idle and all sixteen registers read zero.
- R2: Each memory access keeps mem_cs_o and mem_rd_o high for exactly MEM_LAT consecutive cycles, with mem_size_o = 4 (a byte count) and mem_addr_o held stable. Outside an access, all three are low or zero.
- R3: The fetch reads the word at pc_o. When the fetch completes, pc_o advances by 4.
- R4: The opcode in bits 31:28 goes through a 4-to-16 one-hot decode, and only opcode 5 selects the multiply.
- R5: A multiply makes a second access at the address in bits 23:0 of the instruction, after the fetch access.
- R6: A multiply writes the low 32 bits of the signed product REG[r] × MEM[addr] into register r, where r is bits 27:24 (for example 3 × 0xFFFFFFFF = 0xFFFFFFFD).
- R7: An opcode other than 5 makes no operand access, leaves every register unchanged and goes straight back to fetch.
- R8: retire_o is high for exactly one cycle per instruction: in the write-back cycle of a multiply, or in the decode cycle of a no-op.
- R9: host_we_i writes host_wdata_i into register host_idx_i at the next clock edge. If the core writes back to the same register in the same cycle, the core's value is kept. A host write to a different register in that cycle also lands.
- R10: host_rdata_o shows register host_ridx_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_cs_o | output | 1 | Memory chip select |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_size_o | output | 3 | Access size in bytes (4 during an access, else 0) |
| mem_addr_o | output | 24 | Byte address of the access |
| mem_rdata_i | input | 32 | Read data, valid on the last cycle of an access |
| host_we_i | input | 1 | Register preload write enable |
| host_idx_i | input | 4 | Register preload index |
| host_wdata_i | input | 32 | Register preload data |
| host_ridx_i | input | 4 | Register inspect index |
| host_rdata_o | output | 32 | Register inspect data |
| pc_o | output | 24 | Program counter |
| retire_o | output | 1 | One-cycle strobe per completed instruction |

## Verification
The assertions check the following on every cycle:
- chip select, read and size move together (R2);
- every access starts with a full latency count and holds its address (R2, R5);
- a completed fetch moves the program counter by exactly 4 (R3);
- a decoded no-op returns to fetch with the bus idle (R7);
- retire never lasts two cycles (R8);
- a same-cycle host/core write collision keeps the core value (R9).

Only the bench's directed program can show the arithmetic: signed wrap-around results such as 3 × −1 and 7 × 0x80000000. The bench program also shows that the second access really targets the instruction's address field, that opcodes 0, 3 and 15 leave the registers untouched, and the exact access count and cycle count per instruction.

// File: rtl/mpy_seq_pkg.sv
package mpy_seq_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned AW    = 24;
  localparam int unsigned OP_W  = 4;
  localparam int unsigned RI_W  = 4;
  localparam int unsigned OP_N  = 1 << OP_W;
  localparam logic [OP_W-1:0] OP_MPY = 4'd5;
  localparam logic [2:0] SIZE_WORD = 3'd4;

  typedef enum logic [2:0] {
    S_FETCH_REQ,
    S_FETCH_WAIT,
    S_DECODE,
    S_EXEC_REQ,
    S_EXEC_WAIT,
    S_WRITEBACK
  } state_e;
endpackage

// File: rtl/mpy_seq_dec.sv
module mpy_seq_dec #(
  parameter int unsigned OP_W = 4,
  localparam int unsigned OP_N = 1 << OP_W
) (
  input  logic [OP_W-1:0] op_i,
  output logic [OP_N-1:0] hot_o
);
  for (genvar i = 0; i < OP_N; i++) begin : g_line
    assign hot_o[i] = (op_i == OP_W'(i));
  end
endmodule

// File: rtl/mpy_seq_mul.sv
module mpy_seq_mul #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o
);
  // low DW bits of a two's-complement product do not depend on signedness
  assign y_o = a_i * b_i;
endmodule

// File: rtl/mpy_seq_rf.sv
module mpy_seq_rf #(
  parameter int unsigned DW = 32,
  parameter int unsigned IW = 4,
  localparam int unsigned DEPTH = 1 << IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_a_i,
  input  logic [IW-1:0] idx_a_i,
  input  logic [DW-1:0] wd_a_i,
  input  logic          we_b_i,
  input  logic [IW-1:0] idx_b_i,
  input  logic [DW-1:0] wd_b_i,
  input  logic [IW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o
);
  logic [DW-1:0] regs_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[i] <= '0;
      else if (we_a_i && idx_a_i == IW'(i))      regs_q[i] <= wd_a_i;
      else if (we_b_i && idx_b_i == IW'(i))      regs_q[i] <= wd_b_i;
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];

  // R9: port A (core) wins a same-index collision
  p_core_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a_i && we_b_i && idx_a_i == idx_b_i) |=> regs_q[$past(idx_a_i)] == $past(wd_a_i));
endmodule

// File: rtl/mpy_seq.sv
module mpy_seq
  import mpy_seq_pkg::*;
#(
  parameter int unsigned    MEM_LAT   = 100,
  parameter logic [AW-1:0]  RESET_VEC = 24'h000100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             mem_cs_o,
  output logic             mem_rd_o,
  output logic [2:0]       mem_size_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             host_we_i,
  input  logic [RI_W-1:0]  host_idx_i,
  input  logic [XLEN-1:0]  host_wdata_i,
  input  logic [RI_W-1:0]  host_ridx_i,
  output logic [XLEN-1:0]  host_rdata_o,
  output logic [AW-1:0]    pc_o,
  output logic             retire_o
);
  localparam int unsigned     CNT_W    = $clog2(MEM_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MEM_LAT - 1);
  localparam logic [OP_N-1:0]  MPY_LINE = OP_N'(1) << OP_MPY;

  state_e           st_q;
  logic [AW-1:0]    pc_q, mar_q;
  logic [XLEN-1:0]  mdr_q, ir_q;
  logic [CNT_W-1:0] cnt_q;

  logic [OP_N-1:0]  op_hot;
  logic             is_mpy, is_nop, access, core_we;
  logic [XLEN-1:0]  reg_val, alu_y;

  wire [OP_W-1:0] ir_op  = ir_q[XLEN-1 -: OP_W];
  wire [RI_W-1:0] ir_reg = ir_q[XLEN-OP_W-1 -: RI_W];
  wire [AW-1:0]   ir_adr = ir_q[AW-1:0];

  mpy_seq_dec #(.OP_W(OP_W)) u_dec (.op_i(ir_op), .hot_o(op_hot));

  assign is_mpy = |(op_hot & MPY_LINE);
  assign is_nop = |(op_hot & ~MPY_LINE);

  mpy_seq_rf #(.DW(XLEN), .IW(RI_W)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_a_i   (core_we),
    .idx_a_i  (ir_reg),
    .wd_a_i   (alu_y),
    .we_b_i   (host_we_i),
    .idx_b_i  (host_idx_i),
    .wd_b_i   (host_wdata_i),
    .ra_idx_i (ir_reg),
    .ra_data_o(reg_val),
    .rb_idx_i (host_ridx_i),
    .rb_data_o(host_rdata_o)
  );

  mpy_seq_mul #(.DW(XLEN)) u_mul (.a_i(reg_val), .b_i(mdr_q), .y_o(alu_y));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_FETCH_REQ;
      pc_q  <= RESET_VEC;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_FETCH_REQ: begin
          mar_q <= pc_q;
          cnt_q <= CNT_LOAD;
          st_q  <= S_FETCH_WAIT;
        end
        S_FETCH_WAIT: begin
          if (cnt_q == '0) begin
            mdr_q <= mem_rdata_i;
            ir_q  <= mem_rdata_i;
            pc_q  <= pc_q + AW'(4);
            st_q  <= S_DECODE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_DECODE: begin
          if (is_mpy) begin
            mar_q <= ir_adr;
            st_q  <= S_EXEC_REQ;
          end else begin
            st_q  <= S_FETCH_REQ;
          end
        end
        S_EXEC_REQ: begin
          cnt_q <= CNT_LOAD;
          st_q  <= S_EXEC_WAIT;
        end
        S_EXEC_WAIT: begin
          if (cnt_q == '0) begin
            mdr_q <= mem_rdata_i;
            st_q  <= S_WRITEBACK;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_WRITEBACK: st_q <= S_FETCH_REQ;
        default:     st_q <= S_FETCH_REQ;
      endcase
    end
  end

  assign access     = (st_q == S_FETCH_WAIT) || (st_q == S_EXEC_WAIT);
  assign core_we    = (st_q == S_WRITEBACK);
  assign mem_cs_o   = access;
  assign mem_rd_o   = access;
  assign mem_size_o = access ? SIZE_WORD : 3'd0;
  assign mem_addr_o = mar_q;
  assign pc_o       = pc_q;
  assign retire_o   = core_we || (st_q == S_DECODE && is_nop);

  p_bus_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_o ? (mem_rd_o && mem_size_o == SIZE_WORD) : (!mem_rd_o && mem_size_o == 3'd0));

  p_wait_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_cs_o) |-> cnt_q == CNT_LOAD);

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cs_o && $past(mem_cs_o)) |-> $stable(mem_addr_o));

  p_pc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_FETCH_WAIT && cnt_q == '0) |=> pc_o == $past(pc_o) + AW'(4));

  p_nop_skip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_DECODE && is_nop) |=> (st_q == S_FETCH_REQ && !mem_cs_o));

  p_retire_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);
endmodule

// File: tb/mpy_seq_tb.sv
module mpy_seq_tb;
  localparam int unsigned LAT = 100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_cs_o, mem_rd_o, retire_o;
  logic [2:0]  mem_size_o;
  logic [23:0] mem_addr_o, pc_o;
  logic [31:0] mem_rdata_i, host_rdata_o;
  logic        host_we_i = 1'b0;
  logic [3:0]  host_idx_i = '0, host_ridx_i = '0;
  logic [31:0] host_wdata_i = '0;

  logic [31:0] mem [256];

  int checks = 0, errors = 0;
  int cs_cycles = 0, cs_rises = 0, prev_cycles = 0, prev_rises = 0;
  logic        cs_prev = 1'b0;
  logic [23:0] last_addr = '0;
  bit          done = 0;

  always #4 clk_i = ~clk_i;

  assign mem_rdata_i = mem[mem_addr_o[9:2]];

  mpy_seq #(.MEM_LAT(LAT), .RESET_VEC(24'h000100)) u_dut (
    .clk_i, .rst_ni, .mem_cs_o, .mem_rd_o, .mem_size_o, .mem_addr_o, .mem_rdata_i,
    .host_we_i, .host_idx_i, .host_wdata_i, .host_ridx_i, .host_rdata_o, .pc_o, .retire_o
  );

  always @(negedge clk_i) begin
    cs_prev <= mem_cs_o;
    if (mem_cs_o) cs_cycles <= cs_cycles + 1;
    if (mem_cs_o && !cs_prev) begin
      cs_rises  <= cs_rises + 1;
      last_addr <= mem_addr_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [3:0] idx, output logic [31:0] val);
    host_ridx_i = idx;
    #1 val = host_rdata_o;
  endtask

  task automatic host_write(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk_i);
    host_we_i = 1'b1; host_idx_i = idx; host_wdata_i = val;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  // wait for one instruction, check bus activity, pc, retire width and a register
  task automatic run_instr(input string name, input logic [23:0] exp_pc, input int exp_rises,
                           input logic [23:0] exp_addr, input logic [3:0] ridx,
                           input logic [31:0] rexp, input bit hw, input logic [3:0] hidx,
                           input logic [31:0] hval);
    int n = 0;
    logic [31:0] v;
    do begin
      @(negedge clk_i); #1; n++;
    end while (!retire_o && n < 2000);
    if (!retire_o) begin
      checks++; errors++;
      $display("FAIL R8 %s: no retire, actual 0 expected 1", name);
      return;
    end
    if (hw) begin
      host_we_i = 1'b1; host_idx_i = hidx; host_wdata_i = hval;
    end
    chk({name, " R5 access count"}, 32'(cs_rises - prev_rises), 32'(exp_rises));
    chk({name, " R2 select cycles"}, 32'(cs_cycles - prev_cycles), 32'(exp_rises * LAT));
    if (exp_rises == 2) chk({name, " R5 operand address"}, 32'(last_addr), 32'(exp_addr));
    @(negedge clk_i); #1;
    host_we_i = 1'b0;
    chk({name, " R8 retire width"}, 32'(retire_o), 32'd0);
    chk({name, " R3 pc"}, 32'(pc_o), 32'(exp_pc));
    read_reg(ridx, v);
    chk({name, " R6 R7 register"}, v, rexp);
    prev_rises  = cs_rises;
    prev_cycles = cs_cycles;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    int bad = 0;
    chk("R1 reset pc", 32'(pc_o), 32'h100);
    chk("R1 reset bus idle", {29'd0, mem_cs_o, mem_rd_o, |mem_size_o}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      read_reg(4'(i), v);
      if (v !== 32'd0) bad++;
    end
    chk("R1 R10 reset registers zero", 32'(bad), 32'd0);
  endtask

  task automatic t_preload();
    logic [31:0] v;
    host_write(4'd1, 32'd3);
    host_write(4'd2, 32'd7);
    host_write(4'd15, 32'h12345678);
    host_write(4'd3, 32'd5);
    read_reg(4'd15, v);
    chk("R9 R10 preload readback", v, 32'h12345678);
  endtask

  task automatic t_program();
    logic [31:0] v;
    // R6: 3 * -1
    run_instr("mpy_r1", 24'h104, 2, 24'h40, 4'd1, 32'hFFFFFFFD, 0, 4'd0, 32'd0);
    // R7: opcode 3 leaves R2
    run_instr("nop_op3", 24'h108, 1, 24'h0, 4'd2, 32'd7, 0, 4'd0, 32'd0);
    // R6: 7 * 0x80000000 wraps
    run_instr("mpy_r2", 24'h10C, 2, 24'h44, 4'd2, 32'h80000000, 0, 4'd0, 32'd0);
    // R6 + R9: R15 result, host writes R4 in the same cycle
    run_instr("mpy_r15", 24'h110, 2, 24'h48, 4'd15, 32'h23456780, 1, 4'd4, 32'h55);
    read_reg(4'd4, v);
    chk("R9 host write beside core write", v, 32'h55);
    // R7 + R4: opcode 15 leaves R1
    run_instr("nop_op15", 24'h114, 1, 24'h0, 4'd1, 32'hFFFFFFFD, 0, 4'd0, 32'd0);
    // R9: host collides with core on R3, core value kept
    run_instr("mpy_r3_clash", 24'h118, 2, 24'h40, 4'd3, 32'hFFFFFFFB, 1, 4'd3, 32'hDEAD);
    // R7 + R4: opcode 0 leaves R0
    run_instr("nop_op0", 24'h11C, 1, 24'h0, 4'd0, 32'd0, 0, 4'd0, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h40 >> 2]  = 32'hFFFFFFFF;
    mem[8'h44 >> 2]  = 32'h80000000;
    mem[8'h48 >> 2]  = 32'h00000010;
    mem[10'h100 >> 2] = 32'h51000040;
    mem[10'h104 >> 2] = 32'h32000080;
    mem[10'h108 >> 2] = 32'h52000044;
    mem[10'h10C >> 2] = 32'h5F000048;
    mem[10'h110 >> 2] = 32'hF1000040;
    mem[10'h114 >> 2] = 32'h53000040;
    mem[10'h118 >> 2] = 32'h00000000;
    repeat (3) @(negedge clk_i);
    #1 t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_preload();
    t_program();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule